// File: doc/BRIEF.md
# Programmable Event Timer with One-Shot and Auto-Reload Modes

This block is a down-counting event timer advanced by an external one-microsecond strobe. Software programs it through a trigger register, which holds a run flag, an auto-reload flag and an n-1 tick count. It watches the live count and acknowledges expiries through a status register. When the counter is at zero and a strobe arrives, the block raises an active-high, level interrupt. The interrupt stays high until software acknowledges it.

In one-shot mode the hardware drops the run flag at expiry, so the timer fires once. In auto-reload mode the counter is refilled from the programmed count and keeps running. A count of `(1000000/HZ)-1` therefore produces a periodic tick at HZ. Writing zero to the trigger register stops the timer. Register writes take one cycle. Reads are combinational from the selected register.

Top module: `evt_timer`

## Requirements
- R1: After reset, both registers read 0 and `irq_o` is low.
- R2: A write to the trigger register (`wr_sel_i`=0) behaves as follows:
  - bit 31 sets the run flag, bit 30 sets auto-reload, and bits [28:0] set the count.
  - The count is loaded into both the reload value and the live counter.
  - Bit 29 is discarded.
  - The trigger register reads back as {run, reload-mode, 0, count}.
- R3: While running, the live counter drops by one on each cycle with `tick_i` high. It does not change on cycles without `tick_i`, and it does not change while the run flag is clear.
- R4: A `tick_i` with the run flag set and the counter at 0 is an expiry, which sets the interrupt. A programmed count N therefore expires on the (N+1)-th tick.
- R5: In one-shot mode, an expiry clears the run flag. The counter then stays at 0 and no further expiry occurs.
- R6: In auto-reload mode, an expiry reloads the counter with the programmed count and the timer keeps running. A count of 9999 gives one expiry every 10000 ticks.
- R7: Writing 0 to the trigger register stops the timer. No expiry follows, and the status register reads 0 once the interrupt has been acknowledged.
- R8: The interrupt stays high until a write to the status register (`wr_sel_i`=1) with bit 30 set. A status write with bit 30 clear leaves it unchanged.
- R9: The status register (`rd_sel_i`=1) reads the live count in bits [28:0] and the pending interrupt in bit 30. All other bits read 0.
- R10: When an acknowledge and an expiry fall in the same cycle, the interrupt remains set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-microsecond strobe, one cycle wide |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | Write target: 0 trigger, 1 status |
| wr_data_i | input | 32 | Write data |
| rd_sel_i | input | 1 | Read source: 0 trigger, 1 status |
| rd_data_o | output | 32 | Read data of the selected register |
| irq_o | output | 1 | Level interrupt, active high |

## Verification
The bench builds the timer with its default 29-bit count. This lets it read back the largest count, 0x1fffffff, and confirm that bit 29 is discarded. Random counts are kept below 64 so that many one-shot and auto-reload runs fit in the cycle budget. A directed 9999 auto-reload run checks the 10000-tick period edge exactly: no interrupt one tick early, and an interrupt on the tick itself.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;
  localparam int DATA_W   = 32;
  localparam int CNT_W    = 29;
  localparam int RUN_POS  = 31;
  localparam int AUTO_POS = 30;
  localparam int ACK_POS  = 30;
  localparam int PEND_POS = 30;

  typedef enum logic {SEL_TRIG = 1'b0, SEL_STAT = 1'b1} reg_sel_e;

  function automatic logic [DATA_W-1:0] pack_trig(input logic run, input logic auto_rl,
                                                  input logic [CNT_W-1:0] cnt);
    logic [DATA_W-1:0] w;
    w = '0;
    w[RUN_POS] = run;
    w[AUTO_POS] = auto_rl;
    w[CNT_W-1:0] = cnt;
    return w;
  endfunction

  function automatic logic [DATA_W-1:0] pack_stat(input logic [CNT_W-1:0] cnt, input logic pend);
    logic [DATA_W-1:0] w;
    w = '0;
    w[PEND_POS] = pend;
    w[CNT_W-1:0] = cnt;
    return w;
  endfunction

  function automatic logic [CNT_W-1:0] next_count(input logic [CNT_W-1:0] cur, input logic auto_rl,
                                                  input logic [CNT_W-1:0] reload);
    if (cur != '0) return cur - 1'b1;
    return auto_rl ? reload : '0;
  endfunction
endpackage

// File: rtl/evt_timer_regs.sv
module evt_timer_regs
  import evt_timer_pkg::*;
#(
  parameter int CNT_W = evt_timer_pkg::CNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig_wr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              expire,
  output logic              run,
  output logic              auto_rl,
  output logic [CNT_W-1:0]  reload
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run     <= 1'b0;
      auto_rl <= 1'b0;
      reload  <= '0;
    end else if (trig_wr) begin
      run     <= wr_data[RUN_POS];
      auto_rl <= wr_data[AUTO_POS];
      reload  <= wr_data[CNT_W-1:0];
    end else if (expire && !auto_rl) begin
      run <= 1'b0;
    end
  end
endmodule

// File: rtl/evt_timer_count.sv
module evt_timer_count
  import evt_timer_pkg::*;
#(
  parameter int CNT_W = evt_timer_pkg::CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             run,
  input  logic             auto_rl,
  input  logic [CNT_W-1:0] reload,
  input  logic             tick,
  output logic [CNT_W-1:0] count,
  output logic             expire
);
  logic step;
  assign step   = run && tick && !load;
  assign expire = step && (count == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    count <= '0;
    else if (load) count <= load_val;
    else if (step) count <= next_count(count, auto_rl, reload);
  end
endmodule

// File: rtl/evt_timer_irq.sv
module evt_timer_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic set_ev,
  input  logic ack,
  output logic pend
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pend <= 1'b0;
    else if (set_ev) pend <= 1'b1;
    else if (ack)    pend <= 1'b0;
  end
endmodule

// File: rtl/evt_timer.sv
module evt_timer
  import evt_timer_pkg::*;
#(
  parameter int CNT_W = evt_timer_pkg::CNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic              wr_sel_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_sel_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              irq_o
);
  logic             trig_wr_w, ack_w, expire_w, run_w, auto_w;
  logic [CNT_W-1:0] reload_w, count_w;

  assign trig_wr_w = wr_en_i && (reg_sel_e'(wr_sel_i) == SEL_TRIG);
  assign ack_w     = wr_en_i && (reg_sel_e'(wr_sel_i) == SEL_STAT) && wr_data_i[ACK_POS];

  evt_timer_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .trig_wr(trig_wr_w), .wr_data(wr_data_i),
    .expire(expire_w), .run(run_w), .auto_rl(auto_w), .reload(reload_w)
  );

  evt_timer_count #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst_n(rst_n), .load(trig_wr_w), .load_val(wr_data_i[CNT_W-1:0]),
    .run(run_w), .auto_rl(auto_w), .reload(reload_w), .tick(tick_i),
    .count(count_w), .expire(expire_w)
  );

  evt_timer_irq u_irq (
    .clk(clk), .rst_n(rst_n), .set_ev(expire_w), .ack(ack_w), .pend(irq_o)
  );

  always_comb begin
    if (reg_sel_e'(rd_sel_i) == SEL_STAT) rd_data_o = pack_stat(count_w, irq_o);
    else                                  rd_data_o = pack_trig(run_w, auto_w, reload_w);
  end
endmodule

// File: rtl/evt_timer_chk.sv
module evt_timer_chk #(
  parameter int CNT_W = 29
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             load,
  input logic             ack,
  input logic             expire,
  input logic             run,
  input logic             auto_rl,
  input logic [CNT_W-1:0] reload,
  input logic [CNT_W-1:0] count,
  input logic             irq
);
  a_r4_expire_sets_irq: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> irq);
  a_r10_expire_beats_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && ack) |=> irq);
  a_r8_irq_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !ack) |=> irq);
  a_r8_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !expire) |=> !irq);
  a_r5_oneshot_stops: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !auto_rl) |=> !run);
  a_r6_auto_reloads: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && auto_rl) |=> (count == $past(reload)));
  a_r3_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load) |=> $stable(count));
  a_r3_hold_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !load) |=> $stable(count));
endmodule

bind evt_timer evt_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick_i), .load(trig_wr_w), .ack(ack_w),
  .expire(expire_w), .run(run_w), .auto_rl(auto_w), .reload(reload_w),
  .count(count_w), .irq(irq_o)
);

// File: tb/evt_timer_bench.sv
module evt_timer_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_i = 1'b0, wr_en_i = 1'b0, wr_sel_i = 1'b0, rd_sel_i = 1'b0;
  logic [31:0] wr_data_i = '0;
  logic [31:0] rd_data_o;
  logic        irq_o;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  evt_timer u_evt_timer (.clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_en_i(wr_en_i),
    .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i), .rd_sel_i(rd_sel_i),
    .rd_data_o(rd_data_o), .irq_o(irq_o));

  function automatic logic [31:0] want_trig(bit run, bit auto_rl, int unsigned n);
    return {run, auto_rl, 1'b0, n[28:0]};
  endfunction
  function automatic logic [31:0] want_stat(int unsigned n, bit pend);
    return {1'b0, pend, 1'b0, n[28:0]};
  endfunction
  function automatic logic [31:0] cmd(bit run, bit auto_rl, int unsigned n);
    return (run ? 32'h8000_0000 : 32'h0) | (auto_rl ? 32'h4000_0000 : 32'h0) | (n & 32'h1fff_ffff);
  endfunction

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic rd(bit sel, output logic [31:0] v);
    rd_sel_i = sel; #1; v = rd_data_o;
  endtask

  task automatic wr(bit sel, logic [31:0] d);
    @(negedge clk); wr_en_i = 1; wr_sel_i = sel; wr_data_i = d;
    @(negedge clk); wr_en_i = 0;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_i = 1;
      @(negedge clk); tick_i = 0;
    end
  endtask

  task automatic ack();
    wr(1'b1, 32'h4000_0000);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int unsigned n;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    rd(0, v); check("R1 trig", v, 32'h0);
    rd(1, v); check("R1 stat", v, 32'h0);
    check("R1 irq", {31'b0, irq_o}, 32'h0);

    // R2 field decode, bit 29 dropped, max count
    wr(0, 32'hFFFF_FFFF);
    rd(0, v); check("R2 trig max", v, 32'hDFFF_FFFF);
    rd(1, v); check("R9 stat max", v, want_stat(32'h1fff_ffff, 0));
    wr(0, 32'h0);

    // R3 stopped counter holds, idle cycles hold
    wr(0, cmd(0, 0, 7)); ticks(4);
    rd(1, v); check("R3 hold stopped", v, want_stat(7, 0));
    wr(0, cmd(1, 0, 7)); repeat (5) @(negedge clk);
    rd(1, v); check("R3 hold no tick", v, want_stat(7, 0));
    ticks(2);
    rd(1, v); check("R3 decrement", v, want_stat(5, 0));
    wr(0, 32'h0);

    // R4/R5 random one-shot runs
    for (int k = 0; k < 6; k++) begin
      n = $urandom_range(40, 0);
      if (k == 0) n = 0;
      wr(0, cmd(1, 0, n)); ticks(n);
      check("R4 no early irq", {31'b0, irq_o}, 32'h0);
      rd(1, v); check("R3 count at zero", v, want_stat(0, 0));
      ticks(1);
      check("R4 irq on N+1", {31'b0, irq_o}, 32'h1);
      rd(0, v); check("R5 run cleared", v, want_trig(0, 0, n));
      ticks(3);
      rd(1, v); check("R5 stays stopped", v, want_stat(0, 1));
      wr(1, 32'hBFFF_FFFF);
      check("R8 ack without bit30", {31'b0, irq_o}, 32'h1);
      ack();
      rd(1, v); check("R8 ack clears", v, want_stat(0, 0));
    end

    // R6 random auto-reload runs
    for (int k = 0; k < 6; k++) begin
      n = $urandom_range(60, 0);
      wr(0, cmd(1, 1, n)); ticks(n + 1);
      rd(1, v); check("R6 reload after expiry", v, want_stat(n, 1));
      ack(); ticks(n);
      check("R6 no early second", {31'b0, irq_o}, 32'h0);
      ticks(1);
      check("R6 second expiry", {31'b0, irq_o}, 32'h1);
      rd(0, v); check("R6 still running", v, want_trig(1, 1, n));
      ack();
    end

    // R6 HZ=100 period
    wr(0, cmd(1, 1, 9999)); ticks(9999);
    check("R6 hz early", {31'b0, irq_o}, 32'h0);
    ticks(1);
    check("R6 hz period", {31'b0, irq_o}, 32'h1);
    ack();

    // R7 stop by writing zero
    wr(0, cmd(1, 1, 5)); ticks(2);
    wr(0, 32'h0); ticks(10);
    rd(1, v); check("R7 stopped stat", v, 32'h0);
    rd(0, v); check("R7 stopped trig", v, 32'h0);

    // R10 ack and expiry in one cycle
    wr(0, cmd(1, 0, 0)); ticks(1);
    check("R10 pre pending", {31'b0, irq_o}, 32'h1);
    wr(0, cmd(1, 0, 0));
    check("R8 trig write keeps irq", {31'b0, irq_o}, 32'h1);
    @(negedge clk); tick_i = 1; wr_en_i = 1; wr_sel_i = 1; wr_data_i = 32'h4000_0000;
    @(negedge clk); tick_i = 0; wr_en_i = 0;
    check("R10 expiry wins", {31'b0, irq_o}, 32'h1);
    ack();
    check("R10 later ack", {31'b0, irq_o}, 32'h0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule